// File: doc/BRIEF.md
# Timed Factor Display Sequencer

This block drives a single hex digit and a decimal point on a seven-segment display. It shows, one at a time, the divisors of an 8-bit input value that lie between 1 and 15. Each divisor stays on the display for one second. The divisors come in ascending order, and after the largest one the sequence starts again from the smallest. An upstream divisibility detector supplies three inputs: a 15-bit divisor mask, a prime flag and an 8-bit prime-factor mask. This block only decides what to show and when. It contains the one-second tick divider, the divisor stepping logic and the hex-to-segment decoder.

When the input value is zero, the block enters a debug mode. The digit counts 1 through 15 once per second and wraps. The auxiliary output carries the low byte of a cycle counter that runs freely. The decimal point is dark.

Top module: `factor_digit_cycler`

## Requirements
- R1: While reset is held, the digit register is 1, so `seg` shows the pattern for 1. The cycle counter is 0, so `aux` is 0 when `num_in` is zero.
- R2: The digit changes only on a tick, and a tick occurs once every `TICK_CYCLES` clock cycles. The first update lands on the `TICK_CYCLES`-th rising edge after reset is released. The default is 10,000,000 cycles, which is one second at 10 MHz.
- R3: With `num_in` zero, each tick advances the digit by one, and the digit goes from 15 back to 1.
- R4: With `num_in` zero, `aux` equals the low 8 bits of a counter that is cleared by reset and grows by one on every rising edge.
- R5: With `num_in` nonzero, `aux` equals `prime_fac`. Bit 0 of `prime_fac` stands for 2, then 3, 5, 7, 11, 13, 17, and bit 7 stands for 19.
- R6: `dp` is high only when `num_in` is nonzero and `prime_in` is high.
- R7: With `num_in` nonzero, each tick picks the next digit as follows. It is the smallest divisor above the current digit that is set in `div_mask`. If there is none, it is the lowest set divisor. Bit k-1 of `div_mask` means that k divides the input.
- R8: If the input changes so that the current digit is no longer a set divisor, the next tick still applies the R7 rule. The digit then lands on a set divisor.
- R9: `seg` is active-high, with segment a on bit 0 through segment g on bit 6. The patterns are:
  - 1=06, 2=5B, 3=4F, 4=66, 5=6D
  - 6=7D, 7=07, 8=7F, 9=6F, A=77
  - b=7C, C=39, d=5E, E=79, F=71 (hex)
- R10: The digit is always in the range 1 to 15. If a tick arrives with `num_in` nonzero and `div_mask` all zero, the digit becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_in | input | 8 | Value whose divisors are displayed |
| div_mask | input | 15 | Bit k-1 set when k divides `num_in` |
| prime_in | input | 1 | High when `num_in` is prime |
| prime_fac | input | 8 | Prime-factor flags for 2,3,5,7,11,13,17,19 |
| seg | output | 7 | Segments a..g, active-high, a on bit 0 |
| dp | output | 1 | Decimal point, lit for a prime input |
| aux | output | 8 | Prime-factor flags, or the cycle counter byte in debug mode |

## Verification
On every cycle, the embedded assertions check several things:
- The digit never leaves 1 to 15.
- The digit holds still between ticks.
- The ticks are spaced correctly.
- Debug mode steps the digit up with wrap.
- After a normal-mode tick, the digit sits on a divisor flagged in the mask that was presented.
- The debug byte rises by one per cycle.
- The decimal point stays dark in debug mode.

Only the bench's scenarios can show the rest:
- the full ascending order of the displayed divisors;
- recovery after the input changes to a value the current digit does not divide;
- the exact segment patterns;
- the exact tick timing measured from reset.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  localparam int DIG_W  = 4;
  localparam int MASK_W = 15;
  localparam int SEG_W  = 7;

  // Debug-mode step: 1..15 then wrap to 1.
  function automatic logic [DIG_W-1:0] count_step(input logic [DIG_W-1:0] cur);
    return (cur == DIG_W'(MASK_W)) ? DIG_W'(1) : cur + DIG_W'(1);
  endfunction

  // Smallest set divisor above cur, else the smallest set divisor, else 1.
  function automatic logic [DIG_W-1:0] divisor_step(input logic [DIG_W-1:0]  cur,
                                                    input logic [MASK_W-1:0] mask);
    logic [DIG_W-1:0] above, lowest;
    logic             got_above, got_lowest;
    above = '0; lowest = '0; got_above = 1'b0; got_lowest = 1'b0;
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (mask[i]) begin
        lowest     = DIG_W'(i + 1);
        got_lowest = 1'b1;
        if (DIG_W'(i + 1) > cur) begin
          above     = DIG_W'(i + 1);
          got_above = 1'b1;
        end
      end
    end
    if (got_above)       return above;
    else if (got_lowest) return lowest;
    else                 return DIG_W'(1);
  endfunction

  // Hex digit to active-high segments, a on bit 0.
  function automatic logic [SEG_W-1:0] hex_segments(input logic [DIG_W-1:0] d);
    case (d)
      4'h0: return 7'h3F;
      4'h1: return 7'h06;
      4'h2: return 7'h5B;
      4'h3: return 7'h4F;
      4'h4: return 7'h66;
      4'h5: return 7'h6D;
      4'h6: return 7'h7D;
      4'h7: return 7'h07;
      4'h8: return 7'h7F;
      4'h9: return 7'h6F;
      4'hA: return 7'h77;
      4'hB: return 7'h7C;
      4'hC: return 7'h39;
      4'hD: return 7'h5E;
      4'hE: return 7'h79;
      default: return 7'h71;
    endcase
  endfunction
endpackage

// File: rtl/fdc_tick_div.sv
module fdc_tick_div #(
  parameter int TICK_CYCLES = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else                    div_cnt <= div_cnt + CW'(1);
  end

  assign tick = (div_cnt == LAST);

  generate
    if (TICK_CYCLES > 1) begin : g_spacing
      AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    end
  endgenerate
  AST_DIV_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= LAST); // R2
endmodule

// File: rtl/fdc_digit_seq.sv
module fdc_digit_seq
  import fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              debug_mode,
  input  logic [MASK_W-1:0] div_mask,
  output logic [DIG_W-1:0]  digit
);
  logic [DIG_W-1:0] digit_next;

  always_comb begin
    digit_next = debug_mode ? count_step(digit) : divisor_step(digit, div_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    digit <= DIG_W'(1);
    else if (tick) digit <= digit_next;
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (digit != '0) && (digit <= DIG_W'(MASK_W))); // R10
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(digit)); // R2
  AST_DEBUG_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && debug_mode) |=>
      (digit == (($past(digit) == DIG_W'(MASK_W)) ? DIG_W'(1) : $past(digit) + DIG_W'(1)))); // R3
  AST_LANDS_ON_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !debug_mode && (div_mask != '0)) |=>
      ((($past(div_mask) >> (digit - DIG_W'(1))) & MASK_W'(1)) != '0)); // R7
endmodule

// File: rtl/fdc_seg_dec.sv
module fdc_seg_dec
  import fdc_pkg::*;
(
  input  logic [DIG_W-1:0] digit,
  output logic [SEG_W-1:0] seg
);
  always_comb seg = hex_segments(digit);
endmodule

// File: rtl/factor_digit_cycler.sv
module factor_digit_cycler
  import fdc_pkg::*;
#(
  parameter int TICK_CYCLES = 10_000_000,
  parameter int NUM_W       = 8,
  parameter int AUX_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_W-1:0]  num_in,
  input  logic [MASK_W-1:0] div_mask,
  input  logic              prime_in,
  input  logic [AUX_W-1:0]  prime_fac,
  output logic [SEG_W-1:0]  seg,
  output logic              dp,
  output logic [AUX_W-1:0]  aux
);
  logic             tick;
  logic             debug_mode;
  logic [DIG_W-1:0] digit;
  logic [AUX_W-1:0] cyc_cnt;

  assign debug_mode = (num_in == '0);

  fdc_tick_div #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  fdc_digit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .debug_mode(debug_mode),
    .div_mask(div_mask), .digit(digit)
  );

  fdc_seg_dec u_dec (.digit(digit), .seg(seg));

  always_ff @(posedge clk) begin
    if (!rst_n) cyc_cnt <= '0;
    else        cyc_cnt <= cyc_cnt + AUX_W'(1);
  end

  assign aux = debug_mode ? cyc_cnt : prime_fac;
  assign dp  = !debug_mode && prime_in;

  // Arms one cycle after reset so $past never reaches into reset.
  logic ast_armed;
  always_ff @(posedge clk) begin
    if (!rst_n) ast_armed <= 1'b0;
    else        ast_armed <= 1'b1;
  end

  AST_DP_DARK_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode |-> !dp); // R6
  AST_AUX_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_armed && debug_mode && $past(debug_mode)) |-> (aux == $past(aux) + AUX_W'(1))); // R4
  AST_AUX_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !debug_mode |-> (aux == prime_fac)); // R5
endmodule

// File: tb/factor_digit_cycler_tb.sv
module factor_digit_cycler_tb;
  localparam int T = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  num_in = '0;
  logic [14:0] div_mask = '0;
  logic        prime_in = 1'b0;
  logic [7:0]  prime_fac = '0;
  logic [6:0]  seg;
  logic        dp;
  logic [7:0]  aux;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int exp_dig = 1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  factor_digit_cycler #(.TICK_CYCLES(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .num_in(num_in), .div_mask(div_mask),
    .prime_in(prime_in), .prime_fac(prime_fac), .seg(seg), .dp(dp), .aux(aux)
  );

  function automatic bit is_prime(int n);
    if (n < 2) return 1'b0;
    for (int d = 2; d < n; d++) if (n % d == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [14:0] mask_of(int n);
    logic [14:0] m = '0;
    if (n == 0) return m;
    for (int k = 1; k <= 15; k++) if (n % k == 0) m[k-1] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] pfac_of(int n);
    logic [7:0] f = '0;
    int b = 0;
    for (int p = 2; p <= 19; p++) begin
      if (is_prime(p)) begin
        if (n != 0 && n % p == 0) f[b] = 1'b1;
        b++;
      end
    end
    return f;
  endfunction

  // Segments built from lit letters: a=1 b=2 c=4 d=8 e=16 f=32 g=64
  function automatic logic [6:0] segs_of(int d);
    int a = 1, b = 2, c = 4, dd = 8, e = 16, f = 32, g = 64;
    int r;
    case (d)
      1: r = b | c;
      2: r = a | b | g | e | dd;
      3: r = a | b | g | c | dd;
      4: r = f | g | b | c;
      5: r = a | f | g | c | dd;
      6: r = a | f | e | dd | c | g;
      7: r = a | b | c;
      8: r = a | b | c | dd | e | f | g;
      9: r = a | b | c | dd | f | g;
      10: r = a | b | c | e | f | g;
      11: r = f | e | dd | c | g;
      12: r = a | f | e | dd;
      13: r = b | c | dd | e | g;
      14: r = a | f | g | e | dd;
      default: r = a | f | g | e;
    endcase
    return 7'(r);
  endfunction

  function automatic int model_step(int cur, int n, logic [14:0] m);
    if (n == 0) return (cur == 15) ? 1 : cur + 1;
    for (int c = cur + 1; c <= 15; c++) if (m[c-1]) return c;
    for (int c = 1; c <= 15; c++) if (m[c-1]) return c;
    return 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(int n);
    num_in    = 8'(n);
    div_mask  = mask_of(n);
    prime_in  = is_prime(n);
    prime_fac = pfac_of(n);
  endtask

  // One full period: check hold before the tick, then the new digit after it.
  task automatic period();
    int prev = exp_dig;
    repeat (T - 1) @(posedge clk);
    @(negedge clk);
    edges += T - 1;
    chk("R2 hold", int'(seg), int'(segs_of(prev)));
    @(posedge clk);
    @(negedge clk);
    edges += 1;
    exp_dig = model_step(prev, int'(num_in), div_mask);
    chk("R7/R3/R9 digit", int'(seg), int'(segs_of(exp_dig)));
    chk("R10 range", int'(exp_dig >= 1 && exp_dig <= 15), 1);
    chk("R6 dp", int'(dp), int'(num_in != 0 && is_prime(int'(num_in))));
    if (num_in == 0) chk("R4 aux counter", int'(aux), edges % 256);
    else             chk("R5 aux prime flags", int'(aux), int'(pfac_of(int'(num_in))));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    apply(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset seg", int'(seg), int'(segs_of(1)));
    chk("R1 reset aux", int'(aux), 0);
    chk("R6 dp in debug", int'(dp), 0);
    rst_n = 1'b1;
    // R3: full debug sweep including wrap 15 -> 1
    for (int i = 0; i < 16; i++) period();
    // R7 directed sequences
    apply(6);
    for (int i = 0; i < 5; i++) period();
    apply(7);
    for (int i = 0; i < 3; i++) period();
    apply(23);
    for (int i = 0; i < 2; i++) period();
    // R8: reach 12, then switch to an input 12 does not divide
    apply(12);
    while (exp_dig != 12) period();
    apply(7);
    period();
    chk("R8 recovered digit", exp_dig, 1);
    // R10: nonzero input with empty mask
    apply(10);
    period();
    div_mask = '0;
    period();
    chk("R10 empty mask", int'(seg), int'(segs_of(1)));
    // Random mix
    for (int i = 0; i < 40; i++) begin
      int n = int'($urandom_range(0, 255));
      if (i % 7 == 0) n = 0;
      apply(n);
      period();
      if (n != 0) period();
    end
    done = 1'b1;
  end

  initial begin
    int waited = 0;
    while (!done && waited < 100000) begin
      @(posedge clk);
      waited++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule